// File: doc/BRIEF.md
# Scatter-Gather Sample DMA Engine

This block drains packed sample words from an on-board staging FIFO into host memory without any per-word help from the host processor. Each 32-bit FIFO word holds two 16-bit samples. Every sample carries a 14-bit two's-complement value in its upper bits, and its two lowest bits are forced to zero on the way out. The engine forms write bursts that never run past 32 words and never cross a 4 KB page. It stalls cleanly whenever the FIFO runs dry.

Software picks one of two modes when it pulses `start`. In single-block mode the engine takes one 64-bit destination address and a word count, and it refuses any count above 2M words. In chained mode it reads four-word descriptors from memory through a one-word read port, one descriptor at a time. Descriptors may form a ring that repeats until software asks it to stop. In both modes nothing moves until the acquisition trigger arrives.

Top module: `sg_dma_engine`

## Requirements
- R1: In single-block mode the engine writes exactly `blk_words` words to consecutive word addresses, starting at the full 64-bit `blk_addr`. It pulses `seg_done` once and then returns to idle.
- R2: After `start`, no descriptor read and no write take place until `trigger` has been seen high. `busy` stays high while the engine waits.
- R3: A single-block `start` with `blk_words` above 2097152 performs no transfer and sets `len_err`. `len_err` stays set until reset, even through later good transfers.
- R4: Every burst announced by `wr_start` has a `wr_len` between 1 and 32 words.
- R5: No burst crosses a 4 KB boundary: `wr_addr[11:0] + 4*wr_len` is at most 4096. A segment is cut into as many bursts as needed.
- R6: While `fifo_empty` is high, `wr_valid` is low. Every accepted beat pops exactly one FIFO word, so the written data sequence loses no word and repeats no word.
- R7: `wr_data` equals the popped FIFO word with bits 17, 16, 1 and 0 cleared, and all other bits unchanged.
- R8: A descriptor at pointer P is read as four words:
  - P+0 gives the low half of the destination address.
  - P+4 gives the high half of the destination address.
  - P+8 gives the size in words.
  - P+12 gives the next pointer. Bits 3:0 of the next pointer are dropped when forming the address, and bit 0 set marks the last descriptor.
- R9: A descriptor of size zero issues no write and gives no `seg_done`. The engine moves on to the next descriptor.
- R10: `seg_done` is a one-cycle pulse at the end of each non-empty descriptor. `seg_index` is 0 for the first descriptor after `start` and rises by one for each descriptor fetched after it.
- R11: A chain that links back on itself repeats without end. A `stop` pulse ends the run after the descriptor that is in progress completes, and the engine then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted while idle) |
| stop | input | 1 | Request end of run at next descriptor boundary |
| sg_mode | input | 1 | 1 = descriptor chain, 0 = single block |
| trigger | input | 1 | Acquisition trigger |
| blk_addr | input | 64 | Single-block destination byte address |
| blk_words | input | 32 | Single-block length in words |
| chain_head | input | 32 | Address of first descriptor |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Descriptor word byte address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| fifo_pop | output | 1 | FIFO read strobe |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_word | input | 32 | FIFO head word (show-ahead) |
| wr_start | output | 1 | Burst header strobe |
| wr_addr | output | 64 | Burst / current beat byte address |
| wr_len | output | 6 | Burst length in words |
| wr_valid | output | 1 | Write beat valid |
| wr_data | output | 32 | Write beat data |
| wr_ready | input | 1 | Write beat accepted |
| busy | output | 1 | Engine not idle |
| seg_done | output | 1 | Descriptor finished pulse |
| seg_index | output | 8 | Index of current descriptor |
| len_err | output | 1 | Sticky oversize single-block error |

## Verification
The pointer and remaining-count state are the easiest to corrupt. A fault in either shows up as a wrong `wr_addr` or `wr_len` on the very next `wr_start`, or as a word total that disagrees with the programmed size once `busy` falls. A fault in the pop path shows up on the first beat after a FIFO stall: the data sequence shifts or repeats. A wrong boundary or stop decision shows up as a missing or extra `seg_done` pulse and a wrong final `seg_index`, all within one descriptor.

// File: rtl/sg_dma_engine.sv
module sg_dma_engine #(
  parameter int MAX_BURST = 32,
  parameter int CAP_WORDS = 2097152,
  parameter int IDXW      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop,
  input  logic            sg_mode,
  input  logic            trigger,
  input  logic [63:0]     blk_addr,
  input  logic [31:0]     blk_words,
  input  logic [31:0]     chain_head,
  output logic            rd_req,
  output logic [31:0]     rd_addr,
  input  logic            rd_valid,
  input  logic [31:0]     rd_data,
  output logic            fifo_pop,
  input  logic            fifo_empty,
  input  logic [31:0]     fifo_word,
  output logic            wr_start,
  output logic [63:0]     wr_addr,
  output logic [$clog2(MAX_BURST):0] wr_len,
  output logic            wr_valid,
  output logic [31:0]     wr_data,
  input  logic            wr_ready,
  output logic            busy,
  output logic            seg_done,
  output logic [IDXW-1:0] seg_index,
  output logic            len_err
);
  localparam int BLW = $clog2(MAX_BURST) + 1;
  localparam logic [31:0] CAP  = 32'(CAP_WORDS);
  localparam logic [31:0] MAXB = 32'(MAX_BURST);
  localparam logic [31:0] SAMPLE_MASK = 32'hFFFC_FFFC;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_FETCH, S_EVAL, S_CMD, S_DATA, S_SEG} st_t;
  st_t st;

  logic [1:0]     wi;
  logic [63:0]    cur_addr;
  logic [31:0]    rem, nxt;
  logic [BLW-1:0] beats, blen;
  logic           sg_q, stop_q;

  wire [31:0] room32  = 32'((13'h1000 - {1'b0, cur_addr[11:0]}) >> 2);
  wire [31:0] cap_rem = (rem > MAXB) ? MAXB : rem;
  assign blen = (cap_rem > room32) ? room32[BLW-1:0] : cap_rem[BLW-1:0];

  wire chain_end = !sg_q || nxt[0] || stop_q;

  assign busy     = (st != S_IDLE);
  assign rd_req   = (st == S_FETCH) && !rd_valid;
  assign rd_addr  = (nxt & ~32'hF) + {28'b0, wi, 2'b00};
  assign wr_start = (st == S_CMD);
  assign wr_len   = blen;
  assign wr_addr  = cur_addr;
  assign wr_valid = (st == S_DATA) && !fifo_empty;
  assign wr_data  = fifo_word & SAMPLE_MASK;
  assign fifo_pop = wr_valid && wr_ready;
  assign seg_done = (st == S_SEG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wi        <= '0;
      cur_addr  <= '0;
      rem       <= '0;
      nxt       <= '0;
      beats     <= '0;
      sg_q      <= 1'b0;
      stop_q    <= 1'b0;
      seg_index <= '0;
      len_err   <= 1'b0;
    end else begin
      if (stop && st != S_IDLE) stop_q <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          stop_q    <= 1'b0;
          seg_index <= '0;
          sg_q      <= sg_mode;
          cur_addr  <= blk_addr;
          rem       <= blk_words;
          nxt       <= chain_head;
          wi        <= '0;
          if (!sg_mode && blk_words > CAP) len_err <= 1'b1;
          else st <= S_ARM;
        end
        S_ARM: begin
          if (stop_q)       st <= S_IDLE;
          else if (trigger) st <= sg_q ? S_FETCH : S_EVAL;
        end
        S_FETCH: if (rd_valid) begin
          wi <= wi + 2'd1;
          case (wi)
            2'd0: cur_addr[31:0]  <= rd_data;
            2'd1: cur_addr[63:32] <= rd_data;
            2'd2: rem             <= rd_data;
            default: begin
              nxt <= rd_data;
              st  <= S_EVAL;
            end
          endcase
        end
        S_EVAL: begin
          if (rem != '0) st <= S_CMD;
          else if (chain_end) st <= S_IDLE;
          else begin
            seg_index <= seg_index + IDXW'(1);
            st        <= S_FETCH;
          end
        end
        S_CMD: begin
          beats <= blen;
          st    <= S_DATA;
        end
        S_DATA: if (fifo_pop) begin
          cur_addr <= cur_addr + 64'd4;
          rem      <= rem - 32'd1;
          beats    <= beats - BLW'(1);
          if (beats == BLW'(1)) st <= (rem == 32'd1) ? S_SEG : S_CMD;
        end
        S_SEG: begin
          if (chain_end) st <= S_IDLE;
          else begin
            seg_index <= seg_index + IDXW'(1);
            st        <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic trig_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)              trig_seen <= 1'b0;
    else if (st == S_IDLE)   trig_seen <= 1'b0;
    else if (trigger)        trig_seen <= 1'b1;
  end

  a_r2_no_move_before_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop || rd_req) |-> trig_seen);
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);
  a_r4_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> (wr_len != '0 && 32'(wr_len) <= MAXB));
  a_r5_no_4k_cross: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> (int'(wr_addr[11:0]) + 4 * int'(wr_len) <= 4096));
  a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> wr_addr == $past(wr_addr) + 64'd4);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |=> !seg_done);
  a_r10_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_index != $past(seg_index)) |-> (seg_index == '0 || seg_index == $past(seg_index) + IDXW'(1)));
endmodule

// File: tb/tb_sg_dma_engine.sv
module tb_sg_dma_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, sg_mode = 0, trigger = 0;
  logic [63:0] blk_addr = '0;
  logic [31:0] blk_words = '0, chain_head = '0;
  logic rd_req, rd_valid = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic fifo_pop, fifo_empty;
  logic [31:0] fifo_word;
  logic wr_start, wr_valid, wr_ready;
  logic [63:0] wr_addr;
  logic [5:0] wr_len;
  logic [31:0] wr_data;
  logic busy, seg_done, len_err;
  logic [7:0] seg_index;

  always #5 clk = ~clk;

  sg_dma_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .sg_mode(sg_mode), .trigger(trigger),
    .blk_addr(blk_addr), .blk_words(blk_words), .chain_head(chain_head),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .fifo_pop(fifo_pop), .fifo_empty(fifo_empty), .fifo_word(fifo_word),
    .wr_start(wr_start), .wr_addr(wr_addr), .wr_len(wr_len), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .busy(busy), .seg_done(seg_done),
    .seg_index(seg_index), .len_err(len_err));

  logic [31:0] dmem [256];
  logic [31:0] seq = '0;
  logic [31:0] cyc = '0;
  logic starve = 0, slow = 0;
  assign fifo_word  = {seq[15:0] ^ 16'hFFFF, seq[15:0]};
  assign fifo_empty = starve && (cyc[1:0] != 2'd0);
  assign wr_ready   = !slow || cyc[0];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) seq <= '0;
    else if (fifo_pop) seq <= seq + 1;
    rd_valid <= rd_req && !rd_valid;
    rd_data  <= dmem[rd_addr[9:2]];
  end

  function automatic logic [31:0] expw(int k);
    return {k[15:0] ^ 16'hFFFF, k[15:0]} & 32'hFFFC_FFFC;
  endfunction

  int nwt = 0, nw = 0, nb = 0, nd = 0, nr = 0, viol = 0, derr = 0;
  logic [63:0] baddr [16];

  always @(negedge clk) if (rst_n) begin
    if (wr_start) begin
      if (nb < 16) baddr[nb] = wr_addr;
      nb++;
      if (wr_len == 0 || wr_len > 32) viol++;
      if (int'(wr_addr[11:0]) + 4 * int'(wr_len) > 4096) viol++;
    end
    if (wr_valid && fifo_empty) viol++;
    if (wr_valid && wr_ready) begin
      if (wr_data != expw(nwt)) derr++;
      nwt++; nw++;
    end
    if (seg_done) nd++;
    if (rd_req) nr++;
  end

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    nw = 0; nb = 0; nd = 0; nr = 0; viol = 0; derr = 0;
  endtask

  task automatic go(bit sg, logic [63:0] a, logic [31:0] n, logic [31:0] h);
    @(posedge clk); #1;
    sg_mode = sg; blk_addr = a; blk_words = n; chain_head = h; start = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic trig();
    @(posedge clk); #1; trigger = 1;
    @(posedge clk); #1; trigger = 0;
  endtask

  task automatic wait_idle();
    do @(posedge clk); while (busy);
    #1;
  endtask

  localparam logic [31:0] TV [5][3] = '{
    '{32'h0000_1000, 32'd10, 32'd1},
    '{32'h0000_1000, 32'd64, 32'd2},
    '{32'h0000_1FF0, 32'd20, 32'd2},
    '{32'h0000_0FC0, 32'd70, 32'd3},
    '{32'h0000_2F80, 32'd33, 32'd2}
  };

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) dmem[i] = '0;
    dmem[16] = 32'h0000_3000; dmem[17] = 32'h7; dmem[18] = 32'd5;  dmem[19] = 32'h86;
    dmem[32] = 32'h0000_5000; dmem[33] = 32'h7; dmem[34] = 32'd0;  dmem[35] = 32'hA0;
    dmem[40] = 32'h0000_6FF0; dmem[41] = 32'h7; dmem[42] = 32'd40; dmem[43] = 32'h1;
    dmem[48] = 32'h0000_8000; dmem[49] = 32'h0; dmem[50] = 32'd3;  dmem[51] = 32'hD0;
    dmem[52] = 32'h0000_9000; dmem[53] = 32'h0; dmem[54] = 32'd3;  dmem[55] = 32'hC0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk(!busy && !len_err && !wr_valid && !rd_req && !seg_done, "reset state", {busy, len_err, wr_valid, rd_req}, 0);

    for (int i = 0; i < 5; i++) begin
      logic [63:0] a;
      a = {32'(i + 1), TV[i][0]};
      starve = (i == 2); slow = (i == 3);
      clr();
      go(0, a, TV[i][1], 0);
      trig();
      wait_idle();
      chk(nw == int'(TV[i][1]), "R1 word count", nw, TV[i][1]);
      chk(baddr[0] == a, "R1 first address", baddr[0], a);
      chk(nb == int'(TV[i][2]), "R5 burst split", nb, TV[i][2]);
      chk(viol == 0, "R4 R5 R6 burst rules", viol, 0);
      chk(derr == 0, "R6 R7 data stream", derr, 0);
      chk(nd == 1, "R10 single done pulse", nd, 1);
    end
    starve = 0; slow = 0;

    clr();
    go(1, 0, 0, 32'h40);
    repeat (20) @(posedge clk);
    #1;
    chk(busy && nw == 0 && nr == 0, "R2 wait for trigger", {nw, nr}, 0);
    trig();
    wait_idle();
    chk(nw == 45, "R8 chain words", nw, 45);
    chk(nd == 2, "R9 no done for empty", nd, 2);
    chk(nb == 4, "R9 burst count", nb, 4);
    chk(baddr[0] == 64'h7_0000_3000, "R8 seg0 addr", baddr[0], 64'h7_0000_3000);
    chk(baddr[1] == 64'h7_0000_6FF0, "R9 skip to seg2", baddr[1], 64'h7_0000_6FF0);
    chk(baddr[2] == 64'h7_0000_7000, "R5 page split", baddr[2], 64'h7_0000_7000);
    chk(baddr[3] == 64'h7_0000_7080, "R4 32-word cap", baddr[3], 64'h7_0000_7080);
    chk(nr == 12, "R8 descriptor reads", nr, 12);
    chk(seg_index == 8'd2, "R10 final index", seg_index, 2);
    chk(viol == 0 && derr == 0, "R7 chain data", viol + derr, 0);

    clr();
    go(1, 0, 0, 32'hC0);
    trig();
    while (nd < 4) @(posedge clk);
    #1 stop = 1;
    @(posedge clk); #1 stop = 0;
    wait_idle();
    chk(nd == 5, "R11 stop at boundary", nd, 5);
    chk(nw == 15, "R11 ring words", nw, 15);
    chk(seg_index == 8'd4, "R11 ring index", seg_index, 4);
    chk(baddr[4] == 64'h8000, "R11 ring wraps", baddr[4], 64'h8000);

    clr();
    go(0, 64'h1000, 32'd2097153, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(len_err && !busy && nw == 0, "R3 oversize rejected", {len_err, busy}, 2'b10);
    go(0, 64'h2000, 32'd8, 0);
    trig();
    wait_idle();
    chk(nw == 8, "R1 after error", nw, 8);
    chk(len_err, "R3 sticky", len_err, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule